// File: doc/BRIEF.md
# Chained Vector Multiply/Add Pipeline

This block is a small vector execution engine. It holds eight vector registers of sixty-four 64-bit integer elements each and runs element-wise vector instructions on two pipelined functional units: a multiplier with three stages and an adder with two stages. Each instruction selects a unit and names one destination and two source registers. It covers the leading elements up to the current vector length, and only the elements that the current mask selects.

A sequencer per unit issues one element per cycle. When a source register is still being filled by an earlier instruction, the later instruction does not wait for the whole register. It takes element i in the same cycle that element i leaves the producing pipeline, and so the two instructions overlap. Operands are placed in the registers through a fill port, and any element can be inspected through a peek port. Instructions arrive over a valid/ready port, and a busy flag shows when work is still in flight.

Top module: `vchain_top`

## Requirements
- R1: The register file holds 8 registers of 64 elements of 64 bits, all zero after reset. A fill write (`fill_we`, register, element, data) is visible on `peek_data` from the following cycle. `peek_data` shows the addressed element combinationally.
- R2: The vector length resets to 64. A length write greater than 64 is stored as 64. An instruction updates only the elements whose index is below the length.
- R3: Mask bit i governs element i. Where the bit is 0, the destination element keeps its old value. The mask resets to all ones.
- R4: `op_kind` 0 writes dst[i] = low 64 bits of src1[i]*src2[i]. `op_kind` 1 writes dst[i] = (src1[i]+src2[i]) mod 2^64.
- R5: Without chaining, an instruction of length L accepted at the clock edge that closes cycle t issues element i in cycle t+1+i. Busy is high for cycles t+1 to t+L+3 on the multiplier and t+1 to t+L+2 on the adder.
- R6: A source register that an in-flight instruction is writing is read element by element, each element in the cycle it leaves the producer's pipeline. A multiply accepted at cycle t, followed by a dependent add accepted at t+1, both of length L, leaves busy high through cycle t+L+5.
- R7: `op_ready` is low while the selected unit is still issuing, while the destination has writes outstanding, or while the destination is a source of an instruction that is still issuing. Two units never write the same register in one cycle.
- R8: An instruction issued with length 0 is accepted at once, changes no register, and leaves busy low.
- R9: Busy rises in the cycle after an instruction of nonzero length is accepted. It stays high up to and including the cycle whose closing edge writes the last element, and then falls.
- R10: The length and mask are captured when an instruction is accepted. Writes to them afterwards do not affect that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlen_we | input | 1 | Write strobe for the vector length |
| vlen | input | 7 | New vector length (clamped to 64) |
| vmask_we | input | 1 | Write strobe for the element mask |
| vmask | input | 64 | New element mask, bit i for element i |
| fill_we | input | 1 | Write one register element |
| fill_reg | input | 3 | Register to fill |
| fill_idx | input | 6 | Element to fill |
| fill_data | input | 64 | Fill data |
| peek_reg | input | 3 | Register to inspect |
| peek_idx | input | 6 | Element to inspect |
| peek_data | output | 64 | Inspected element |
| op_valid | input | 1 | Instruction offered |
| op_ready | output | 1 | Instruction can be accepted |
| op_kind | input | 1 | 0 multiply, 1 add |
| op_dst | input | 3 | Destination register |
| op_src1 | input | 3 | First source register |
| op_src2 | input | 3 | Second source register |
| busy | output | 1 | Work is in flight |

## Verification
An unchained multiply of length L, accepted at the edge that closes cycle t, keeps busy high for cycles t+1 to t+L+3. The adder does the same up to t+L+2, and a chained add behind a multiply keeps busy high through t+L+5. The bench records the cycle of each accept and derives the busy window from these formulas. It compares busy with that window at every falling edge. Register contents are compared against a behavioural reference only once busy has dropped, so every element has been written when it is read. Readiness is sampled one time unit after the inputs are driven, before the next rising edge.

// File: rtl/vchain_pkg.sv
`timescale 1ns/1ps
package vchain_pkg;
  localparam int VC_NREG  = 8;
  localparam int VC_NELEM = 64;
  localparam int VC_DW    = 64;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_ADD = 1'b1
  } vop_e;
endpackage

// File: rtl/vchain_regfile.sv
`timescale 1ns/1ps
module vchain_regfile #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int DW    = 64,
  parameter int NWR   = 3,
  parameter int NRD   = 5,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NWR-1:0] wr_en,
  input  logic [RW-1:0]  wr_reg [NWR],
  input  logic [IW-1:0]  wr_idx [NWR],
  input  logic [DW-1:0]  wr_dat [NWR],
  input  logic [RW-1:0]  rd_reg [NRD],
  input  logic [IW-1:0]  rd_idx [NRD],
  output logic [DW-1:0]  rd_dat [NRD]
);
  logic [DW-1:0] mem [NREG][NELEM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < NELEM; e++)
          mem[r][e] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (wr_en[p]) mem[wr_reg[p]][wr_idx[p]] <= wr_dat[p];
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_dat[g] = mem[rd_reg[g]][rd_idx[g]];
  end

  // the two functional-unit write ports never target one register together
  AST_WR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en[0] && wr_en[1] && wr_reg[0] == wr_reg[1])) else $error("write clash"); // R7
endmodule

// File: rtl/vchain_seq.sv
`timescale 1ns/1ps
module vchain_seq #(
  parameter int NELEM = 64,
  parameter int RW    = 3,
  parameter int IW    = 6,
  parameter int LW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RW-1:0]    st_vd,
  input  logic [RW-1:0]    st_vs1,
  input  logic [RW-1:0]    st_vs2,
  input  logic [LW-1:0]    st_vl,
  input  logic [NELEM-1:0] st_mask,
  input  logic             go,
  output logic             active,
  output logic             issue,
  output logic             iss_we,
  output logic             iss_last,
  output logic [IW-1:0]    idx,
  output logic [RW-1:0]    vd,
  output logic [RW-1:0]    vs1,
  output logic [RW-1:0]    vs2
);
  logic [LW-1:0]    vl_q;
  logic [NELEM-1:0] mask_q;

  assign issue    = active && go;
  assign iss_we   = mask_q[idx];
  assign iss_last = (LW'(idx) + LW'(1)) == vl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      vl_q   <= '0;
      mask_q <= '0;
      vd     <= '0;
      vs1    <= '0;
      vs2    <= '0;
    end else if (start) begin
      active <= (st_vl != '0);
      idx    <= '0;
      vl_q   <= st_vl;
      mask_q <= st_mask;
      vd     <= st_vd;
      vs1    <= st_vs1;
      vs2    <= st_vs2;
    end else if (issue) begin
      if (iss_last) active <= 1'b0;
      else          idx    <= idx + 1'b1;
    end
  end

  AST_VL0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start && st_vl == '0 |=> !active) else $error("zero length started"); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> LW'(idx) < vl_q) else $error("index past length"); // R2
endmodule

// File: rtl/vchain_pipe.sv
`timescale 1ns/1ps
module vchain_pipe
  import vchain_pkg::*;
#(
  parameter int   DW  = 64,
  parameter int   RW  = 3,
  parameter int   IW  = 6,
  parameter int   LAT = 2,
  parameter vop_e OP  = OP_ADD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_we,
  input  logic          in_last,
  input  logic [RW-1:0] in_reg,
  input  logic [IW-1:0] in_idx,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_vld,
  output logic          out_we,
  output logic          out_last,
  output logic [RW-1:0] out_reg,
  output logic [IW-1:0] out_idx,
  output logic [DW-1:0] out_dat,
  output logic          occupied
);
  typedef struct packed {
    logic          vld;
    logic          we;
    logic          last;
    logic [RW-1:0] rg;
    logic [IW-1:0] ix;
    logic [DW-1:0] d;
  } slot_t;

  function automatic logic [DW-1:0] f_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a * b;
  endfunction

  function automatic logic [DW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  slot_t st [LAT];
  slot_t head;

  always_comb begin
    head.vld  = in_vld;
    head.we   = in_we;
    head.last = in_last;
    head.rg   = in_reg;
    head.ix   = in_idx;
    head.d    = (OP == OP_MUL) ? f_mul(in_a, in_b) : f_add(in_a, in_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) st[s] <= '0;
    end else begin
      st[0] <= head;
      for (int s = 1; s < LAT; s++) st[s] <= st[s-1];
    end
  end

  always_comb begin
    occupied = 1'b0;
    for (int s = 0; s < LAT; s++) occupied = occupied | st[s].vld;
  end

  assign out_vld  = st[LAT-1].vld;
  assign out_we   = st[LAT-1].we;
  assign out_last = st[LAT-1].last;
  assign out_reg  = st[LAT-1].rg;
  assign out_idx  = st[LAT-1].ix;
  assign out_dat  = st[LAT-1].d;
endmodule

// File: rtl/vchain_top.sv
`timescale 1ns/1ps
module vchain_top
  import vchain_pkg::*;
#(
  parameter int NREG    = VC_NREG,
  parameter int NELEM   = VC_NELEM,
  parameter int DW      = VC_DW,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 2,
  localparam int RW     = $clog2(NREG),
  localparam int IW     = $clog2(NELEM),
  localparam int LW     = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vlen_we,
  input  logic [LW-1:0]    vlen,
  input  logic             vmask_we,
  input  logic [NELEM-1:0] vmask,
  input  logic             fill_we,
  input  logic [RW-1:0]    fill_reg,
  input  logic [IW-1:0]    fill_idx,
  input  logic [DW-1:0]    fill_data,
  input  logic [RW-1:0]    peek_reg,
  input  logic [IW-1:0]    peek_idx,
  output logic [DW-1:0]    peek_data,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_kind,
  input  logic [RW-1:0]    op_dst,
  input  logic [RW-1:0]    op_src1,
  input  logic [RW-1:0]    op_src2,
  output logic             busy
);
  localparam int NU  = 2;
  localparam int NWR = NU + 1;
  localparam int NRD = 2 * NU + 1;

  logic [LW-1:0]    vl_q;
  logic [NELEM-1:0] mask_q;
  logic [NREG-1:0]  pend;
  logic [LW-1:0]    wcnt [NREG];
  logic             accept;

  logic [NU-1:0] u_act, u_issue, u_we, u_last, u_go, u_start;
  logic [NU-1:0] x_vld, x_we, x_last, u_occ;
  logic [IW-1:0] u_idx [NU];
  logic [RW-1:0] u_vd [NU];
  logic [RW-1:0] u_vs1 [NU];
  logic [RW-1:0] u_vs2 [NU];
  logic [RW-1:0] x_reg [NU];
  logic [IW-1:0] x_idx [NU];
  logic [DW-1:0] x_dat [NU];
  logic [DW-1:0] opa [NU];
  logic [DW-1:0] opb [NU];

  logic [NWR-1:0] wr_en;
  logic [RW-1:0]  wr_reg [NWR];
  logic [IW-1:0]  wr_idx [NWR];
  logic [DW-1:0]  wr_dat [NWR];
  logic [RW-1:0]  rd_reg [NRD];
  logic [IW-1:0]  rd_idx [NRD];
  logic [DW-1:0]  rd_dat [NRD];

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= LW'(NELEM);
      mask_q <= '1;
    end else begin
      if (vlen_we)  vl_q   <= (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;
      if (vmask_we) mask_q <= vmask;
    end
  end

  // issue interlock
  always_comb begin
    op_ready = !u_act[op_kind] && !pend[op_dst];
    for (int u = 0; u < NU; u++)
      if (u_act[u] && (u_vs1[u] == op_dst || u_vs2[u] == op_dst)) op_ready = 1'b0;
  end
  assign accept = op_valid && op_ready;

  // per-register write scoreboard: pending flag plus count of elements written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int r = 0; r < NREG; r++) wcnt[r] <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (x_vld[u]) begin
          wcnt[x_reg[u]] <= wcnt[x_reg[u]] + LW'(1);
          if (x_last[u]) pend[x_reg[u]] <= 1'b0;
        end
      end
      if (accept && vl_q != '0) begin
        pend[op_dst] <= 1'b1;
        wcnt[op_dst] <= '0;
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    for (genvar k = 0; k < 2; k++) begin : g_src
      logic [RW-1:0] s;
      logic          hit0, hit1, ok;
      logic [DW-1:0] dat;
      assign s    = (k == 0) ? u_vs1[u] : u_vs2[u];
      assign hit0 = x_vld[0] && x_reg[0] == s && x_idx[0] == u_idx[u];
      assign hit1 = x_vld[1] && x_reg[1] == s && x_idx[1] == u_idx[u];
      assign ok   = (s == u_vd[u]) || !pend[s] || (wcnt[s] > LW'(u_idx[u])) || hit0 || hit1;
      assign dat  = (hit0 && x_we[0]) ? x_dat[0] :
                    (hit1 && x_we[1]) ? x_dat[1] : rd_dat[2*u+k];
      assign rd_reg[2*u+k] = s;
      assign rd_idx[2*u+k] = u_idx[u];
    end

    assign u_go[u]    = g_src[0].ok && g_src[1].ok;
    assign opa[u]     = g_src[0].dat;
    assign opb[u]     = g_src[1].dat;
    assign u_start[u] = accept && (int'(op_kind) == u);

    vchain_seq #(.NELEM(NELEM), .RW(RW), .IW(IW), .LW(LW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (u_start[u]),
      .st_vd    (op_dst),
      .st_vs1   (op_src1),
      .st_vs2   (op_src2),
      .st_vl    (vl_q),
      .st_mask  (mask_q),
      .go       (u_go[u]),
      .active   (u_act[u]),
      .issue    (u_issue[u]),
      .iss_we   (u_we[u]),
      .iss_last (u_last[u]),
      .idx      (u_idx[u]),
      .vd       (u_vd[u]),
      .vs1      (u_vs1[u]),
      .vs2      (u_vs2[u])
    );

    vchain_pipe #(
      .DW (DW), .RW(RW), .IW(IW),
      .LAT(u == 0 ? MUL_LAT : ADD_LAT),
      .OP (u == 0 ? OP_MUL : OP_ADD)
    ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (u_issue[u]),
      .in_we    (u_we[u]),
      .in_last  (u_last[u]),
      .in_reg   (u_vd[u]),
      .in_idx   (u_idx[u]),
      .in_a     (opa[u]),
      .in_b     (opb[u]),
      .out_vld  (x_vld[u]),
      .out_we   (x_we[u]),
      .out_last (x_last[u]),
      .out_reg  (x_reg[u]),
      .out_idx  (x_idx[u]),
      .out_dat  (x_dat[u]),
      .occupied (u_occ[u])
    );

    assign wr_en[u]  = x_vld[u] && x_we[u];
    assign wr_reg[u] = x_reg[u];
    assign wr_idx[u] = x_idx[u];
    assign wr_dat[u] = x_dat[u];

    // every result leaving a pipe lands in a register the scoreboard still holds open
    AST_WB_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      x_vld[u] |-> pend[x_reg[u]]) else $error("write to idle register"); // R7
  end

  assign wr_en[NU]    = fill_we;
  assign wr_reg[NU]   = fill_reg;
  assign wr_idx[NU]   = fill_idx;
  assign wr_dat[NU]   = fill_data;
  assign rd_reg[2*NU] = peek_reg;
  assign rd_idx[2*NU] = peek_idx;
  assign peek_data    = rd_dat[2*NU];

  vchain_regfile #(.NREG(NREG), .NELEM(NELEM), .DW(DW), .NWR(NWR), .NRD(NRD)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_reg (wr_reg),
    .wr_idx (wr_idx),
    .wr_dat (wr_dat),
    .rd_reg (rd_reg),
    .rd_idx (rd_idx),
    .rd_dat (rd_dat)
  );

  assign busy = (|u_act) || (|u_occ);

  AST_VLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= LW'(NELEM)) else $error("length out of range"); // R2
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past((x_vld[0] && x_last[0]) || (x_vld[1] && x_last[1])))
    else $error("busy fell without final write"); // R9
endmodule

// File: tb/sim_vchain_top.sv
`timescale 1ns/1ps
module sim_vchain_top;
  localparam int NREG = 8, NELEM = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        vlen_we = 0, vmask_we = 0, fill_we = 0, op_valid = 0, op_kind = 0;
  logic [6:0]  vlen = '0;
  logic [63:0] vmask = '0, fill_data = '0, peek_data;
  logic [2:0]  fill_reg = '0, peek_reg = '0, op_dst = '0, op_src1 = '0, op_src2 = '0;
  logic [5:0]  fill_idx = '0, peek_idx = '0;
  logic        op_ready, busy;

  always #2 clk = ~clk;

  vchain_top u0 (
    .clk(clk), .rst_n(rst_n), .vlen_we(vlen_we), .vlen(vlen), .vmask_we(vmask_we), .vmask(vmask),
    .fill_we(fill_we), .fill_reg(fill_reg), .fill_idx(fill_idx), .fill_data(fill_data),
    .peek_reg(peek_reg), .peek_idx(peek_idx), .peek_data(peek_data),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_dst(op_dst),
    .op_src1(op_src1), .op_src2(op_src2), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int b_from = -1, b_to = -1;
  bit bchk = 0;
  string breq = "R9";
  logic [63:0] mdl [NREG][NELEM];
  int mvl = 64;
  logic [63:0] mmask = '1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] want);
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", rq, act, want, cyc);
    end
  endtask

  // busy compared on every falling edge against the window of the latest accept
  always @(negedge clk) begin
    if (bchk) chk(breq, {63'd0, busy}, {63'd0, (cyc > b_from && cyc <= b_to)});
  end

  task automatic set_cfg(int vl, logic [63:0] m);
    vlen_we = 1; vlen = 7'(vl); vmask_we = 1; vmask = m;
    @(negedge clk);
    vlen_we = 0; vmask_we = 0;
    mvl = (vl > 64) ? 64 : vl;
    mmask = m;
  endtask

  // span >= 0 sets the busy window end relative to the accept cycle
  task automatic issue(bit kind, int vd, int s1, int s2, int span);
    op_valid = 1; op_kind = kind; op_dst = 3'(vd); op_src1 = 3'(s1); op_src2 = 3'(s2);
    #1;
    while (!op_ready) begin @(negedge clk); #1; end
    if (span >= 0) begin b_from = cyc; b_to = cyc + span; end
    for (int i = 0; i < mvl; i++)
      if (mmask[i]) mdl[vd][i] = kind ? mdl[s1][i] + mdl[s2][i] : mdl[s1][i] * mdl[s2][i];
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic wait_idle();
    #1;
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic compare_all(string rq);
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < NELEM; e++) begin
        peek_reg = 3'(r); peek_idx = 6'(e);
        #1;
        chk(rq, peek_data, mdl[r][e]);
      end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog act=running exp=idle");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] x;
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < NELEM; e++) mdl[r][e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    #1;
    chk("R1", {63'd0, busy}, 64'd0);
    chk("R7", {63'd0, op_ready}, 64'd1);
    compare_all("R1");

    // R1 fill every element through the fill port
    x = 64'h1234_5678_9abc_def1;
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < NELEM; e++) begin
        x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
        fill_we = 1; fill_reg = 3'(r); fill_idx = 6'(e);
        fill_data = (r == 0 && e == 0) ? '1 : (r == 1 && e == 0) ? 64'd2 : x;
        mdl[r][e] = fill_data;
        @(negedge clk);
      end
    fill_we = 0;
    compare_all("R1");
    bchk = 1;

    // R4 R5 unchained multiply: busy t+1..t+67
    breq = "R5";
    issue(1'b0, 2, 0, 1, 64 + 3);
    wait_idle();
    compare_all("R4");

    // R4 R5 unchained add, wrap at element 0: busy t+1..t+66
    issue(1'b1, 3, 0, 0, 64 + 2);
    wait_idle();
    compare_all("R4");

    // R4 add reading its own destination
    issue(1'b1, 3, 3, 1, 64 + 2);
    wait_idle();
    compare_all("R4");

    // R6 chained multiply -> add, R7 multiplier still streaming
    breq = "R6";
    issue(1'b0, 4, 0, 1, 64 + 5);
    issue(1'b1, 5, 4, 2, -1);
    op_valid = 1; op_kind = 0; op_dst = 3'd6; op_src1 = 3'd0; op_src2 = 3'd0;
    #1;
    chk("R7", {63'd0, op_ready}, 64'd0);
    op_valid = 0;
    wait_idle();
    compare_all("R6");

    // R2 R3 short length with alternating mask
    breq = "R3";
    set_cfg(10, 64'hAAAA_AAAA_AAAA_AAA5);
    issue(1'b1, 6, 0, 1, 10 + 2);
    wait_idle();
    compare_all("R3");

    // R2 length clamp
    breq = "R2";
    set_cfg(100, '1);
    issue(1'b1, 7, 3, 2, 64 + 2);
    wait_idle();
    compare_all("R2");

    // R2 R3 chain through a masked producer at a short length
    breq = "R6";
    set_cfg(17, 64'h0000_0000_0001_6DB5);
    issue(1'b0, 4, 2, 3, 17 + 5);
    issue(1'b1, 5, 4, 4, -1);
    wait_idle();
    compare_all("R3");

    // R8 zero length
    breq = "R8";
    set_cfg(0, '1);
    issue(1'b1, 7, 0, 1, 0);
    repeat (4) @(negedge clk);
    compare_all("R8");

    // R10 capture at accept
    breq = "R10";
    set_cfg(20, '1);
    issue(1'b0, 6, 2, 3, 20 + 3);
    set_cfg(5, '0);
    wait_idle();
    compare_all("R10");

    // R7 destination hazards
    bchk = 0;
    set_cfg(64, '1);
    issue(1'b0, 4, 1, 2, -1);
    op_valid = 1; op_kind = 1; op_dst = 3'd1; op_src1 = 3'd0; op_src2 = 3'd0;
    #1;
    chk("R7", {63'd0, op_ready}, 64'd0);
    op_dst = 3'd4;
    #1;
    chk("R7", {63'd0, op_ready}, 64'd0);
    op_valid = 0;
    @(negedge clk);
    issue(1'b1, 4, 4, 0, -1);
    wait_idle();
    compare_all("R7");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule